// File: doc/BRIEF.md
# NAND Flash Read-Cycle Timing Sequencer

This block runs the data-read phase of a byte-wide NAND flash on a local bus. It drives the active-low chip select and the active-low read strobe, waits for the flash ready line, and captures one byte per read. Its time base is the quarter of a bus cycle. A tick input that pulses four times per bus cycle sets this time base, and every timer in the block moves only on that tick. Four configuration inputs set the waveform: a relaxed-timing bit, a late-rise strobe bit, an extended-hold bit and a 4-bit scale count S. The block samples them once for each accepted read.

A client holds the request line high for as long as it wants more bytes. The sequencer accepts a read from idle, or on the tick that ends the current read cycle, so reads in a burst follow one another with chip select held low. After the last read of a burst, an optional turnaround period keeps chip select high while busy stays asserted. This gives bus drivers time to turn off before any following access. If the flash stays not-ready for too long, the read is dropped and a sticky timeout flag is set.

Top module: `nand_rd_seq`

## Requirements
- R1: After reset, cs_n and re_n are 1 and rd_busy, rd_valid, rd_ack and rd_timeout are 0.
- R2: The read strobe (re_n = 0) stays low for L quarter ticks, where L depends on {cfg_relaxed, cfg_late_rise}: 00 gives 3+4S, 01 gives 4+4S, 10 gives 2+8S and 11 gives 4+8S. re_n is low only while cs_n is low.
- R3: A read cycle lasts C quarter ticks, counted from the tick where the strobe falls: C = 8+4S when cfg_relaxed = 0 and C = 12+8S when cfg_relaxed = 1. After the last read of a burst, cs_n rises when C has elapsed.
- R4: After acceptance, the strobe falls only on a tick where flash_rdy is 1 and at least W ticks of waiting have already passed. W = 4S when cfg_relaxed = 0 and W = 8S when cfg_relaxed = 1. With flash_rdy held at 1, the strobe falls W+1 ticks after acceptance.
- R5: The byte on flash_dq is captured on the tick where re_n returns high. rd_valid pulses for exactly one clock with that byte on rd_data.
- R6: When cfg_ext_hold = 1, the last read of a burst is followed by C quarter ticks in which cs_n = 1 and rd_busy = 1. When cfg_ext_hold = 0, rd_busy falls together with cs_n.
- R7: A request that is present on the tick ending a read cycle is accepted at once. It starts a new read without a hold gap and without releasing cs_n.
- R8: rd_ack pulses for one clock after each acceptance. rd_busy is high from acceptance until the cycle, and any hold, has finished.
- R9: If no strobe has started by the tick where the wait reaches T = 16(2+S) ticks (cfg_relaxed = 0) or T = 32(2+S) ticks (cfg_relaxed = 1), the sequencer returns to idle with cs_n = 1 and sets rd_timeout. A later acceptance clears rd_timeout.
- R10: The configuration inputs are sampled only on acceptance. A change while a read is in progress does not alter that read's waveform.
- R11: On clocks without q_tick, cs_n and re_n hold their values and rd_valid stays 0. All durations scale with the tick period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (quarter-cycle domain) |
| rst | input | 1 | Synchronous active-high reset |
| q_tick | input | 1 | Quarter-bus-cycle enable |
| rd_req | input | 1 | Read request, held high for a burst |
| cfg_relaxed | input | 1 | Doubles the scaled timing terms |
| cfg_late_rise | input | 1 | Lengthens the strobe low time |
| cfg_ext_hold | input | 1 | Adds a chip-select-off gap after a burst |
| cfg_scale | input | 4 | Cycle scaling count S |
| flash_rdy | input | 1 | Flash ready, high when ready |
| flash_dq | input | DATA_W | Flash data bus |
| rd_ack | output | 1 | One-clock acceptance pulse |
| rd_busy | output | 1 | Read cycle or hold in progress |
| cs_n | output | 1 | Active-low chip select |
| re_n | output | 1 | Active-low read strobe |
| rd_data | output | DATA_W | Captured byte |
| rd_valid | output | 1 | One-clock capture pulse |
| rd_timeout | output | 1 | Sticky ready-timeout flag |

## Verification
Bursts run under all four settings of the relaxed and late-rise bits, with scale values 0 through 3, so that each strobe-width formula and both cycle-length formulas give distinct widths. Each burst measures every strobe-low run, every selected-but-idle run and the post-burst gap. These measurements separate the initial wait, the gap between reads and the final recovery, and they show whether the hold gap appears for the extended-hold bit. One burst runs with a tick every fourth clock, which shows that all timing comes from ticks and not from clocks. Separate runs hold the ready line low: a short hold must postpone the strobe, and a long one must end in a timeout. Changing the configuration in the middle of a read must leave that read's widths unchanged.

// File: rtl/nrd_pkg.sv
package nrd_pkg;

    localparam int SCY_W   = 4;
    localparam int SCY_MAX = (1 << SCY_W) - 1;
    localparam int QCNT_W  = $clog2(32 * (SCY_MAX + 2) + 1);

    typedef logic [QCNT_W-1:0] qcnt_t;

    typedef struct packed {
        logic             relaxed;
        logic             late_rise;
        logic             ext_hold;
        logic [SCY_W-1:0] scale;
    } rd_cfg_t;

    typedef struct packed {
        qcnt_t low_q;
        qcnt_t cycle_q;
        qcnt_t hold_q;
        qcnt_t wait_q;
        qcnt_t limit_q;
    } rd_tim_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_STROBE,
        ST_RECOVER,
        ST_HOLD
    } rd_state_e;

    function automatic rd_tim_t derive_timing(rd_cfg_t c);
        rd_tim_t t;
        int      s;
        int      cyc;
        s = int'(c.scale);
        unique case ({c.relaxed, c.late_rise})
            2'b00:   t.low_q = qcnt_t'(3 + 4 * s);
            2'b01:   t.low_q = qcnt_t'(4 + 4 * s);
            2'b10:   t.low_q = qcnt_t'(2 + 8 * s);
            default: t.low_q = qcnt_t'(4 + 8 * s);
        endcase
        cyc       = c.relaxed ? (12 + 8 * s) : (8 + 4 * s);
        t.cycle_q = qcnt_t'(cyc);
        t.hold_q  = c.ext_hold ? qcnt_t'(cyc) : '0;
        t.wait_q  = c.relaxed ? qcnt_t'(8 * s) : qcnt_t'(4 * s);
        t.limit_q = c.relaxed ? qcnt_t'(32 * (2 + s)) : qcnt_t'(16 * (2 + s));
        return t;
    endfunction

endpackage

// File: rtl/nrd_tcalc.sv
module nrd_tcalc
    import nrd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  rd_cfg_t cfg_in,
    output rd_tim_t tim
);

    rd_tim_t tim_next;

    always_comb tim_next = derive_timing(cfg_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            tim <= '0;
        end else if (load) begin
            tim <= tim_next;
        end
    end

endmodule

// File: rtl/nrd_fsm.sv
module nrd_fsm
    import nrd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    q_tick,
    input  logic    req,
    input  logic    flash_rdy,
    input  rd_tim_t tim,
    output logic    load,
    output logic    ack,
    output logic    busy,
    output logic    sel_n,
    output logic    strobe_n,
    output logic    capture,
    output logic    timed_out
);

    rd_state_e st;
    qcnt_t     cnt;
    qcnt_t     cnt_inc;
    logic      end_low;
    logic      end_cyc;
    logic      ready_go;
    logic      expire;
    logic      end_hold;

    always_comb begin
        cnt_inc  = cnt + 1'b1;
        end_low  = (st == ST_STROBE)  && (cnt_inc == tim.low_q);
        end_cyc  = (st == ST_RECOVER) && (cnt_inc == tim.cycle_q);
        end_hold = (st == ST_HOLD)    && (cnt_inc == tim.hold_q);
        ready_go = (st == ST_WAIT) && (cnt >= tim.wait_q) && flash_rdy;
        expire   = (st == ST_WAIT) && !ready_go && (cnt_inc >= tim.limit_q);
        load     = q_tick && req && ((st == ST_IDLE) || end_cyc);
        capture  = q_tick && end_low;
        busy     = (st != ST_IDLE);
        sel_n    = !((st == ST_WAIT) || (st == ST_STROBE) || (st == ST_RECOVER));
        strobe_n = (st != ST_STROBE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            ack       <= 1'b0;
            timed_out <= 1'b0;
        end else begin
            ack <= load;
            if (load) begin
                timed_out <= 1'b0;
            end else if (q_tick && expire) begin
                timed_out <= 1'b1;
            end
            if (q_tick) begin
                unique case (st)
                    ST_IDLE: begin
                        if (req) begin
                            st  <= ST_WAIT;
                            cnt <= '0;
                        end
                    end
                    ST_WAIT: begin
                        if (ready_go) begin
                            st  <= ST_STROBE;
                            cnt <= '0;
                        end else if (expire) begin
                            st  <= ST_IDLE;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt_inc;
                        end
                    end
                    ST_STROBE: begin
                        cnt <= cnt_inc;
                        if (end_low) begin
                            st <= ST_RECOVER;
                        end
                    end
                    ST_RECOVER: begin
                        if (end_cyc) begin
                            cnt <= '0;
                            if (req) begin
                                st <= ST_WAIT;
                            end else if (tim.hold_q != '0) begin
                                st <= ST_HOLD;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt_inc;
                        end
                    end
                    ST_HOLD: begin
                        if (end_hold) begin
                            st  <= ST_IDLE;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt_inc;
                        end
                    end
                    default: begin
                        st  <= ST_IDLE;
                        cnt <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/nrd_capture.sv
module nrd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dvalid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout   <= '0;
            dvalid <= 1'b0;
        end else begin
            dvalid <= capture;
            if (capture) begin
                dout <= din;
            end
        end
    end

endmodule

// File: rtl/nand_rd_seq.sv
module nand_rd_seq
    import nrd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              q_tick,
    input  logic              rd_req,
    input  logic              cfg_relaxed,
    input  logic              cfg_late_rise,
    input  logic              cfg_ext_hold,
    input  logic [SCY_W-1:0]  cfg_scale,
    input  logic              flash_rdy,
    input  logic [DATA_W-1:0] flash_dq,
    output logic              rd_ack,
    output logic              rd_busy,
    output logic              cs_n,
    output logic              re_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_timeout
);

    rd_cfg_t cfg_now;
    rd_tim_t tim;
    logic    load;
    logic    capture;

    always_comb begin
        cfg_now.relaxed   = cfg_relaxed;
        cfg_now.late_rise = cfg_late_rise;
        cfg_now.ext_hold  = cfg_ext_hold;
        cfg_now.scale     = cfg_scale;
    end

    nrd_tcalc u_tcalc (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .cfg_in (cfg_now),
        .tim    (tim)
    );

    nrd_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .q_tick    (q_tick),
        .req       (rd_req),
        .flash_rdy (flash_rdy),
        .tim       (tim),
        .load      (load),
        .ack       (rd_ack),
        .busy      (rd_busy),
        .sel_n     (cs_n),
        .strobe_n  (re_n),
        .capture   (capture),
        .timed_out (rd_timeout)
    );

    nrd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .din     (flash_dq),
        .dout    (rd_data),
        .dvalid  (rd_valid)
    );

    // R2: the strobe may only be active inside a selected cycle
    a_r2_strobe_inside_select: assert property (@(posedge clk) disable iff (rst)
        !re_n |-> !cs_n);

    // R5: a captured byte appears exactly where the strobe has just risen
    a_r5_capture_at_rise: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $rose(re_n));

    // R8: an acknowledged read keeps the sequencer busy
    a_r8_ack_makes_busy: assert property (@(posedge clk) disable iff (rst)
        rd_ack |-> rd_busy);

    // R9: a timeout leaves the bus deselected and the sequencer idle
    a_r9_timeout_releases: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_timeout) |-> (!rd_busy && cs_n));

    // R11: nothing moves on a clock without a quarter tick
    a_r11_frozen_without_tick: assert property (@(posedge clk) disable iff (rst)
        !q_tick |=> ($stable(cs_n) && $stable(re_n) && !rd_valid));

endmodule

// File: tb/nand_rd_seq_test.sv
module nand_rd_seq_test;
    import nrd_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             q_tick = 1'b0;
    logic             rd_req = 1'b0;
    logic             c_rel = 1'b0;
    logic             c_late = 1'b0;
    logic             c_ext = 1'b0;
    logic [SCY_W-1:0] c_scl = '0;
    logic             flash_rdy = 1'b1;
    logic [7:0]       flash_dq = 8'h00;
    logic             rd_ack, rd_busy, cs_n, re_n, rd_valid, rd_timeout;
    logic [7:0]       rd_data;

    nand_rd_seq #(.DATA_W(8)) uut (
        .clk(clk), .rst(rst), .q_tick(q_tick), .rd_req(rd_req),
        .cfg_relaxed(c_rel), .cfg_late_rise(c_late), .cfg_ext_hold(c_ext),
        .cfg_scale(c_scl), .flash_rdy(flash_rdy), .flash_dq(flash_dq),
        .rd_ack(rd_ack), .rd_busy(rd_busy), .cs_n(cs_n), .re_n(re_n),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_timeout(rd_timeout)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int tick_div = 1;
    int tick_ph = 0;
    int q_low[$];
    int q_high[$];
    logic [7:0] q_data[$];
    int exp_hold = 0;
    bit chk_high = 1'b1;
    int drv_idx = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_byte(input int i);
        return 8'(i * 29 + 90) ^ 8'h5A;
    endfunction

    function automatic int low_t(input bit tr, input bit rs, input int s);
        if (!tr) return rs ? 4 + 4 * s : 3 + 4 * s;
        return rs ? 4 + 8 * s : 2 + 8 * s;
    endfunction
    function automatic int cyc_t(input bit tr, input int s);
        return tr ? 12 + 8 * s : 8 + 4 * s;
    endfunction
    function automatic int ws_t(input bit tr, input int s);
        return tr ? 8 * s : 4 * s;
    endfunction
    function automatic int to_t(input bit tr, input int s);
        return tr ? 32 * (2 + s) : 16 * (2 + s);
    endfunction

    // quarter-tick generator
    always @(negedge clk) begin
        if (tick_div <= 1) begin
            q_tick <= 1'b1;
        end else begin
            q_tick  <= (tick_ph == 0);
            tick_ph <= (tick_ph + 1) % tick_div;
        end
    end

    // flash model and monitor / scoreboard
    int   fl_idx = 0;
    int   low_run = 0;
    int   high_run = 0;
    int   gap_run = 0;
    logic re_prev = 1'b1;
    logic busy_prev = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (re_prev && !re_n) begin
                flash_dq <= model_byte(fl_idx);
                fl_idx++;
            end
            re_prev = re_n;

            if (!re_n) begin
                low_run++;
            end else if (low_run > 0) begin
                if (q_low.size() == 0) check(1'b0, "R2 unexpected strobe", low_run, 0);
                else begin
                    int e;
                    e = q_low.pop_front();
                    check(low_run == e, "R2 strobe low width", low_run, e);
                end
                low_run = 0;
            end

            if (!cs_n && re_n) begin
                high_run++;
            end else if (high_run > 0) begin
                if (chk_high) begin
                    if (q_high.size() == 0) check(1'b0, "R3 unexpected select run", high_run, 0);
                    else begin
                        int e;
                        e = q_high.pop_front();
                        check(high_run == e, "R3/R4/R7/R9 selected idle run", high_run, e);
                    end
                end
                high_run = 0;
            end

            if (rd_busy && cs_n) gap_run++;
            if (busy_prev && !rd_busy) begin
                check(gap_run == exp_hold, "R6 hold gap", gap_run, exp_hold);
                gap_run = 0;
            end
            busy_prev = rd_busy;

            if (rd_valid) begin
                if (q_data.size() == 0) check(1'b0, "R5 unexpected data", int'(rd_data), 0);
                else begin
                    logic [7:0] e;
                    e = q_data.pop_front();
                    check(rd_data == e, "R5 captured byte", int'(rd_data), int'(e));
                end
            end
        end
    end

    task automatic wait_idle();
        while (rd_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // driver: pushes expected results and runs a burst of n reads
    task automatic burst(input int n, input bit tr, input bit rs, input bit eh,
                         input int s, input bit scramble);
        int lo, cy, ws, p, acks;
        p  = tick_div;
        lo = low_t(tr, rs, s);
        cy = cyc_t(tr, s);
        ws = ws_t(tr, s);
        @(negedge clk);
        c_rel = tr; c_late = rs; c_ext = eh; c_scl = SCY_W'(s);
        exp_hold = eh ? cy * p : 0;
        for (int k = 0; k < n; k++) begin
            q_low.push_back(lo * p);
            q_data.push_back(model_byte(drv_idx));
            drv_idx++;
            if (k == 0) q_high.push_back((ws + 1) * p);
            else        q_high.push_back((cy - lo + ws + 1) * p);
        end
        q_high.push_back((cy - lo) * p);
        rd_req = 1'b1;
        acks = 0;
        while (acks < n) begin
            @(negedge clk);
            if (rd_ack) begin
                acks++;
                check(rd_busy == 1'b1, "R8 busy at ack", int'(rd_busy), 1);
            end
        end
        rd_req = 1'b0;
        if (scramble) begin
            c_rel = ~tr; c_late = ~rs; c_ext = ~eh; c_scl = SCY_W'(s + 3);
        end
        wait_idle();
        check(cs_n == 1'b1, "R3 deselected after burst", int'(cs_n), 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
        check(re_n == 1'b1, "R1 re_n", int'(re_n), 1);
        check(rd_busy == 1'b0, "R1 busy", int'(rd_busy), 0);
        check(rd_valid == 1'b0, "R1 valid", int'(rd_valid), 0);
        check(rd_ack == 1'b0, "R1 ack", int'(rd_ack), 0);
        check(rd_timeout == 1'b0, "R1 timeout", int'(rd_timeout), 0);

        // R2 R3 R4 R7 formula variants, with and without hold (R6)
        burst(3, 1'b0, 1'b0, 1'b0, 0, 1'b0);
        burst(2, 1'b0, 1'b1, 1'b1, 1, 1'b0);
        burst(2, 1'b1, 1'b0, 1'b1, 2, 1'b0);
        burst(3, 1'b1, 1'b1, 1'b0, 0, 1'b0);
        burst(1, 1'b1, 1'b1, 1'b1, 3, 1'b0);

        // R10 configuration changed mid-read does not matter
        burst(1, 1'b0, 1'b0, 1'b0, 0, 1'b1);

        // R11 slower tick: every duration scales by four
        tick_div = 4;
        burst(2, 1'b0, 1'b0, 1'b1, 1, 1'b0);
        tick_div = 1;
        repeat (4) @(negedge clk);

        // R4 strobe waits for ready
        @(negedge clk);
        flash_rdy = 1'b0;
        chk_high = 1'b0;
        c_rel = 1'b0; c_late = 1'b0; c_ext = 1'b0; c_scl = SCY_W'(3);
        exp_hold = 0;
        q_low.push_back(low_t(1'b0, 1'b0, 3));
        q_data.push_back(model_byte(drv_idx));
        drv_idx++;
        rd_req = 1'b1;
        while (!rd_ack) @(negedge clk);
        rd_req = 1'b0;
        repeat (30) @(negedge clk);
        check(re_n == 1'b1, "R4 strobe held while not ready", int'(re_n), 1);
        check(cs_n == 1'b0, "R4 selected while waiting", int'(cs_n), 0);
        flash_rdy = 1'b1;
        wait_idle();
        chk_high = 1'b1;
        check(rd_timeout == 1'b0, "R9 no timeout on late ready", int'(rd_timeout), 0);

        // R9 timeout
        @(negedge clk);
        flash_rdy = 1'b0;
        c_rel = 1'b1; c_late = 1'b0; c_ext = 1'b1; c_scl = SCY_W'(0);
        exp_hold = 0;
        q_high.push_back(to_t(1'b1, 0));
        rd_req = 1'b1;
        while (!rd_ack) @(negedge clk);
        rd_req = 1'b0;
        wait_idle();
        check(rd_timeout == 1'b1, "R9 timeout flag", int'(rd_timeout), 1);
        check(cs_n == 1'b1, "R9 deselected", int'(cs_n), 1);
        flash_rdy = 1'b1;
        burst(1, 1'b0, 1'b1, 1'b0, 0, 1'b0);
        check(rd_timeout == 1'b0, "R9 flag cleared", int'(rd_timeout), 0);

        check(q_low.size() == 0, "R2 strobes missing", q_low.size(), 0);
        check(q_data.size() == 0, "R5 bytes missing", q_data.size(), 0);
        check(q_high.size() == 0, "R3 runs missing", q_high.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R8 watchdog actual=hung expected=idle");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule